// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block stands between seven external processor input pins and the core's internal exception-request and halt lines. Pin activity reaches it as a stream of updates. Each update carries a pin index, a one-bit level and a valid strobe. The block keeps a registered copy of the last level seen on every pin. It acts only when an update really changes that copy, so repeated levels never produce spurious events.

The pins do not all react the same way. Three pins act as active-high levels that drive a request directly: the external interrupt, the thermal interrupt and the soft reset. The machine-check pin reacts only to a falling transition. That transition sets a sticky request, which the core clears with a one-cycle pulse. The checkstop pin drives a halt output. The hard-reset and timebase-enable pins only update their stored copy. The update port has a ready output that is always high, because every update is absorbed in a single cycle. An update is taken in any cycle where valid is high, and no back-pressure is ever applied. Every output is registered and reflects an update one clock edge after it is taken.

Top module: `pinc_top`

## Requirements
- R1: After a synchronous reset, all stored pin levels are 0, and all four request outputs and halt are 0.
- R2: An accepted update to pin index 5 sets ext_req to the update's level at the next clock edge.
- R3: An accepted update to pin index 6 sets therm_req to the update's level at the next clock edge.
- R4: An accepted update to pin index 1 sets sreset_req to the update's level at the next clock edge.
- R5: mck_req is set only when an update to pin index 4 carries level 0 while the stored level of pin 4 is 1. A rising update sets nothing. A repeated 0 update also sets nothing.
- R6: mck_req stays set until a cycle with mck_clear high and no new machine-check fall. If a fall and a clear occur in the same cycle, mck_req stays set.
- R7: An accepted update to pin index 2 with level 1 asserts halt at the next edge, and one with level 0 deasserts it.
- R8: Updates to pin indices 0 and 3 change no output. An update with index 7 is ignored and leaves every stored level unchanged.
- R9: When upd_valid is low, the pin index and level inputs have no effect. upd_ready is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Pin update valid |
| upd_ready | output | 1 | Always high: update accepted every cycle |
| upd_pin | input | 3 | Pin index (0 hard reset, 1 soft reset, 2 checkstop, 3 timebase enable, 4 machine check, 5 external, 6 thermal) |
| upd_level | input | 1 | New pin level |
| mck_clear | input | 1 | One-cycle clear of the machine-check request |
| ext_req | output | 1 | External interrupt request |
| therm_req | output | 1 | Thermal interrupt request |
| mck_req | output | 1 | Sticky machine-check request |
| sreset_req | output | 1 | Soft-reset interrupt request |
| halt | output | 1 | Core halt from checkstop |

## Verification
The bench aims at the machine-check path, which is the easiest part to get wrong. It checks that a rising update or a repeated low update leaves the request clear. A design that skipped the spurious-update filter would raise a false machine check in those cases. It also drives a clear in the same cycle as a new fall. A design with clear priority would drop that request. Updates to index 7 and to pins 0 and 3 are followed by a machine-check fall. A design that aliased the index or corrupted the stored level of pin 4 would then miss the request. Held-low valid with live index and level inputs shows whether the design ignores the valid strobe.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam int NUM_PINS = 7;
  localparam int PIN_W    = $clog2(NUM_PINS + 1);

  typedef enum logic [PIN_W-1:0] {
    PIN_HRST  = 3'd0,
    PIN_SRST  = 3'd1,
    PIN_CSTOP = 3'd2,
    PIN_TBEN  = 3'd3,
    PIN_MCHK  = 3'd4,
    PIN_EXT   = 3'd5,
    PIN_THERM = 3'd6
  } pin_id_e;

  typedef struct packed {
    logic             hit;
    logic [PIN_W-1:0] pin;
    logic             level;
  } pin_event_t;
endpackage

// File: rtl/pinc_level_store.sv
module pinc_level_store
  import pinc_pkg::*;
#(
  parameter int N = NUM_PINS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [PIN_W-1:0] upd_pin,
  input  logic             upd_level,
  output logic [N-1:0]     levels,
  output pin_event_t       evt
);
  logic in_range;
  logic cur;

  assign in_range = (int'(upd_pin) < N);
  assign cur      = in_range ? levels[upd_pin] : 1'b0;

  always_comb begin
    evt.hit   = upd_valid && in_range && (cur != upd_level);
    evt.pin   = upd_pin;
    evt.level = upd_level;
  end

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)
        levels[g] <= 1'b0;
      else if (upd_valid && in_range && (int'(upd_pin) == g))
        levels[g] <= upd_level;
    end
  end

  AST_OOR_LEVELS_HELD: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !in_range) |=> $stable(levels)); // R8
endmodule

// File: rtl/pinc_req_map.sv
module pinc_req_map
  import pinc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pin_event_t evt,
  input  logic       mck_clear,
  output logic       ext_req,
  output logic       therm_req,
  output logic       mck_req,
  output logic       sreset_req,
  output logic       halt
);
  logic mck_fall;

  assign mck_fall = evt.hit && (evt.pin == PIN_MCHK) && !evt.level;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_req    <= 1'b0;
      therm_req  <= 1'b0;
      sreset_req <= 1'b0;
      halt       <= 1'b0;
      mck_req    <= 1'b0;
    end else begin
      if (evt.hit) begin
        case (evt.pin)
          PIN_EXT:   ext_req    <= evt.level;
          PIN_THERM: therm_req  <= evt.level;
          PIN_SRST:  sreset_req <= evt.level;
          PIN_CSTOP: halt       <= evt.level;
          default: ;
        endcase
      end
      if (mck_fall)       mck_req <= 1'b1;
      else if (mck_clear) mck_req <= 1'b0;
    end
  end

  AST_MCK_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    mck_fall |=> mck_req); // R6
  AST_MCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mck_req && !mck_clear) |=> mck_req); // R6
endmodule

// File: rtl/pinc_top.sv
module pinc_top
  import pinc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [PIN_W-1:0] upd_pin,
  input  logic             upd_level,
  input  logic             mck_clear,
  output logic             ext_req,
  output logic             therm_req,
  output logic             mck_req,
  output logic             sreset_req,
  output logic             halt
);
  logic [NUM_PINS-1:0] levels;
  pin_event_t          evt;

  assign upd_ready = 1'b1;

  pinc_level_store #(.N(NUM_PINS)) u_store (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .upd_level(upd_level), .levels(levels), .evt(evt)
  );

  pinc_req_map u_map (
    .clk(clk), .rst(rst), .evt(evt), .mck_clear(mck_clear),
    .ext_req(ext_req), .therm_req(therm_req), .mck_req(mck_req),
    .sreset_req(sreset_req), .halt(halt)
  );

  AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_pin == PIN_EXT) |=> (ext_req == $past(upd_level))); // R2
  AST_THERM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_pin == PIN_THERM) |=> (therm_req == $past(upd_level))); // R3
  AST_SRST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_pin == PIN_SRST) |=> (sreset_req == $past(upd_level))); // R4
  AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_pin == PIN_CSTOP) |=> (halt == $past(upd_level))); // R7
  AST_MCK_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
    (!mck_req && !(upd_valid && upd_pin == PIN_MCHK && !upd_level)) |=> !mck_req); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable({ext_req, therm_req, sreset_req, halt})); // R9
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
    upd_ready); // R9
endmodule

// File: tb/tb_pinc_top.sv
module tb_pinc_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_valid = 1'b0;
  logic       upd_ready;
  logic [2:0] upd_pin = '0;
  logic       upd_level = 1'b0;
  logic       mck_clear = 1'b0;
  logic       ext_req, therm_req, mck_req, sreset_req, halt;

  always #2.5 clk = ~clk;

  pinc_top dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pin(upd_pin), .upd_level(upd_level), .mck_clear(mck_clear),
    .ext_req(ext_req), .therm_req(therm_req), .mck_req(mck_req),
    .sreset_req(sreset_req), .halt(halt)
  );

  typedef struct {
    logic [5:0] outs;   // ready, ext, therm, mck, sreset, halt
    string      req;
  } exp_t;

  exp_t expq[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  logic [6:0] m_lvl = '0;
  logic m_ext = 0, m_therm = 0, m_mck = 0, m_srst = 0, m_halt = 0;

  function automatic logic [5:0] obs();
    return {upd_ready, ext_req, therm_req, mck_req, sreset_req, halt};
  endfunction

  // driver: drive inputs at negedge, update the bench model, push expectation
  task automatic apply(input bit v, input int pin, input bit lvl, input bit clr, input string req);
    exp_t e;
    bit fall;
    @(negedge clk);
    upd_valid = v; upd_pin = 3'(pin); upd_level = lvl; mck_clear = clr;
    fall = 0;
    if (v && pin < 7 && m_lvl[pin] != lvl) begin
      case (pin)
        1: m_srst  = lvl;
        2: m_halt  = lvl;
        4: fall    = !lvl;
        5: m_ext   = lvl;
        6: m_therm = lvl;
        default: ;
      endcase
    end
    if (v && pin < 7) m_lvl[pin] = lvl;
    if (fall) m_mck = 1;
    else if (clr) m_mck = 0;
    e.outs = {1'b1, m_ext, m_therm, m_mck, m_srst, m_halt};
    e.req  = req;
    expq.push_back(e);
  endtask

  // monitor: pop and compare shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        n_vec++;
        if (obs() !== e.outs) begin
          n_fail++;
          $display("FAIL %s: outputs {rdy,ext,therm,mck,srst,halt} actual=%b expected=%b",
                   e.req, obs(), e.outs);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_vec++;
    if ({ext_req, therm_req, mck_req, sreset_req, halt} !== 5'b0) begin
      n_fail++;
      $display("FAIL R1: reset outputs actual=%b expected=00000",
               {ext_req, therm_req, mck_req, sreset_req, halt});
    end
    apply(0, 0, 0, 0, "R1");
    // R2 ext level
    apply(1, 5, 1, 0, "R2");
    apply(1, 5, 1, 0, "R2");
    apply(1, 5, 0, 0, "R2");
    // R3 thermal
    apply(1, 6, 1, 0, "R3");
    apply(1, 6, 0, 0, "R3");
    // R4 soft reset
    apply(1, 1, 1, 0, "R4");
    apply(1, 1, 0, 0, "R4");
    // R7 checkstop halt
    apply(1, 2, 1, 0, "R7");
    apply(1, 2, 1, 0, "R7");
    apply(1, 2, 0, 0, "R7");
    // R5 machine check: repeated low, rise, fall
    apply(1, 4, 0, 0, "R5");
    apply(1, 4, 1, 0, "R5");
    apply(1, 4, 0, 0, "R5");
    apply(0, 0, 0, 0, "R6");
    apply(0, 0, 0, 0, "R6");
    apply(0, 0, 0, 1, "R6");
    apply(1, 4, 0, 0, "R5");
    // R6 set wins over clear
    apply(1, 4, 1, 0, "R6");
    apply(1, 4, 0, 1, "R6");
    apply(0, 0, 0, 1, "R6");
    // R8 pins 0/3 and index 7
    apply(1, 4, 1, 0, "R8");
    apply(1, 0, 1, 0, "R8");
    apply(1, 3, 1, 0, "R8");
    apply(1, 7, 0, 0, "R8");
    apply(1, 0, 0, 0, "R8");
    apply(1, 3, 0, 0, "R8");
    apply(1, 4, 0, 0, "R8");
    apply(0, 0, 0, 1, "R8");
    apply(1, 7, 1, 0, "R8");
    apply(1, 4, 0, 0, "R8");
    // R9 valid low ignores index/level
    apply(0, 5, 1, 0, "R9");
    apply(0, 2, 1, 0, "R9");
    apply(0, 4, 1, 0, "R9");
    apply(1, 4, 0, 0, "R9");
    // mixed pattern
    for (int i = 0; i < 40; i++)
      apply(1, (i * 3) % 8, 1'((i >> 1) & 1), 1'(i % 5 == 0), "R2");
    apply(0, 0, 0, 0, "R6");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule